// File: doc/BRIEF.md
# Serial-to-Parallel Word Demultiplexer with Loopback Source Select

This block sits right after clock and data recovery in a high-speed receive path. It runs on the recovered bit clock. It takes one retimed serial bit per enabled cycle from one of two serial sources: the normal line input, or a system loopback input that a local transmitter can drive for diagnostics. It packs the bits into 16-bit words. The first bit received lands in the most significant position.

For every 16 accepted bits the block presents a new word together with a one-cycle valid strobe. A word clock, derived by dividing the accepted-bit count by 16, runs alongside the data. The word clock is low for the first half of each group and high for the second half. The data bus changes only at the falling edge of the word clock, so it is stable around the rising edge for a downstream capture. When the source select changes, any partial group is thrown away and word assembly restarts on the new source.

Top module: `dsr_deser`

## Requirements
- R1: While rst_ni is low, word_o is 0, word_clk_o is 0 and word_vld_o is 0.
- R2: With src_sel_i = 0 the bits come from line_bit_i. With src_sel_i = 1 they come from loop_bit_i. The other input has no effect on word_o.
- R3: Bit ordering is MSB first. Within a group, the first accepted bit appears at word_o[15] and the last at word_o[0].
- R4: A bit is accepted only in a cycle with bit_en_i = 1. A cycle with bit_en_i = 0 leaves word_o, word_clk_o and the group position unchanged, and word_vld_o stays 0.
- R5: After the 16th accepted bit of a group, the next clock edge loads the complete word into word_o and raises word_vld_o for exactly one cycle. word_o changes at no other time.
- R6: word_clk_o is 0 after 0 to 7 accepted bits of the current group and 1 after 8 to 15. It falls at the same edge that loads a new word.
- R7: A cycle in which src_sel_i differs from its value in the previous cycle (0 right after reset) drops that cycle's bit. It also clears the group position, drives word_clk_o to 0 at that edge and raises no strobe. The next word is built only from the 16 bits accepted after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-clock enable; a bit is taken only when high |
| line_bit_i | input | 1 | Normal serial data input |
| loop_bit_i | input | 1 | System loopback serial data input |
| src_sel_i | input | 1 | Source select: 0 line, 1 loopback |
| word_o | output | 16 | Assembled parallel word, MSB received first |
| word_clk_o | output | 1 | Word clock, accepted-bit count divided by 16 |
| word_vld_o | output | 1 | One-cycle strobe when word_o is loaded |

## Verification
A walking-one sweep over all 16 positions, with all-ones, all-zeros and mixed words, shows whether each received bit lands at its own MSB-first position. The unused source is always driven with the complement of the data, so any leak from the wrong input shows up as a flipped word. Disabled cycles with toggling data are inserted between accepted bits. These separate bit acceptance from clock edges, and the bench checks that the word clock phase and the strobe stay put during those cycles. Source switches are applied both on a group boundary and part way through a group, which exposes any partial group that survives the restart.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned DSR_WORD_W = 16;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_LOOP = 1'b1
  } dsr_src_e;
endpackage

// File: rtl/dsr_src_mux.sv
module dsr_src_mux
  import dsr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_sel_i,
  input  logic line_bit_i,
  input  logic loop_bit_i,
  output logic bit_o,
  output logic chg_o
);
  dsr_src_e src_q;
  dsr_src_e src_d;

  assign src_d = dsr_src_e'(src_sel_i);
  assign bit_o = (src_d == SRC_LOOP) ? loop_bit_i : line_bit_i;
  assign chg_o = (src_d != src_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_LINE;
    else         src_q <= src_d;
  end
endmodule

// File: rtl/dsr_word_ctr.sv
module dsr_word_ctr #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic clr_i,
  output logic last_o,
  output logic word_clk_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wclk_q;

  assign last_o = take_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (last_o) cnt_d = '0;
    else if (take_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wclk_q <= (cnt_d >= HALF);
    end
  end

  assign word_clk_o = wclk_q;

  // R4: idle cycles leave the group position alone
  a_r4_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              load_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= load_i;
      if (take_i) sh_q <= {sh_q[WORD_W-3:0], bit_i};
      if (load_i) word_q <= {sh_q, bit_i};
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R5: a strobe needs a full group, so never two in a row
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
endmodule

// File: rtl/dsr_deser.sv
module dsr_deser
  import dsr_pkg::*;
#(
  parameter int unsigned WORD_W = DSR_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              line_bit_i,
  input  logic              loop_bit_i,
  input  logic              src_sel_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_clk_o,
  output logic              word_vld_o
);
  logic sel_bit;
  logic src_chg;
  logic take;
  logic last;

  dsr_src_mux u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_sel_i  (src_sel_i),
    .line_bit_i (line_bit_i),
    .loop_bit_i (loop_bit_i),
    .bit_o      (sel_bit),
    .chg_o      (src_chg)
  );

  // a select change drops the bit of that cycle
  assign take = bit_en_i && !src_chg;

  dsr_word_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .clr_i      (src_chg),
    .last_o     (last),
    .word_clk_o (word_clk_o)
  );

  dsr_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .load_i (last),
    .bit_i  (sel_bit),
    .word_o (word_o),
    .vld_o  (word_vld_o)
  );

  a_r5_word_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o != $past(word_o)) |-> word_vld_o);

  a_r6_fall_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (!word_clk_o && $past(word_clk_o)));

  a_r4_vld_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(bit_en_i));

  a_r7_switch_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_chg |=> (!word_vld_o && !word_clk_o));
endmodule

// File: tb/dsr_deser_test.sv
`timescale 1ns/1ps
module dsr_deser_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        line_bit = 1'b0;
  logic        loop_bit = 1'b0;
  logic        src_sel = 1'b0;
  logic [15:0] word;
  logic        word_clk;
  logic        word_vld;

  int n_chk = 0;
  int n_fail = 0;
  int pos = 0;
  logic [15:0] last_word = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dsr_deser uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bit_en_i   (bit_en),
    .line_bit_i (line_bit),
    .loop_bit_i (loop_bit),
    .src_sel_i  (src_sel),
    .word_o     (word),
    .word_clk_o (word_clk),
    .word_vld_o (word_vld)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle, then sample just after the edge
  task automatic cycle(input logic en, input logic src, input logic b);
    @(negedge clk);
    bit_en   = en;
    src_sel  = src;
    line_bit = src ? ~b : b;
    loop_bit = src ? b : ~b;
    @(posedge clk);
    #1;
  endtask

  task automatic accept_bit(input logic b);
    cycle(1'b1, src_sel, b);
    pos = (pos + 1) % 16;
    check(word_clk == (pos >= 8), "R6 word clock phase", 16'(word_clk), 16'(pos >= 8));
    check(word_vld == (pos == 0), "R5 strobe", 16'(word_vld), 16'(pos == 0));
    if (pos != 0)
      check(word == last_word, "R5 word held", word, last_word);
  endtask

  task automatic idle_cycle(input logic b);
    cycle(1'b0, src_sel, b);
    check(word_vld == 1'b0, "R4 no strobe when idle", 16'(word_vld), 16'h0);
    check(word_clk == (pos >= 8), "R4 phase held when idle", 16'(word_clk), 16'(pos >= 8));
    check(word == last_word, "R4 word held when idle", word, last_word);
  endtask

  task automatic send_word(input logic [15:0] w, input int gap, input string req);
    for (int i = 15; i >= 0; i--) begin
      for (int g = 0; g < gap; g++) idle_cycle(logic'(g[0]) ^ w[i]);
      accept_bit(w[i]);
    end
    check(word == w, req, word, w);
    last_word = w;
  endtask

  task automatic switch_src(input logic src);
    cycle(1'b1, src, 1'b1);
    pos = 0;
    check(word_vld == 1'b0, "R7 no strobe on switch", 16'(word_vld), 16'h0);
    check(word_clk == 1'b0, "R7 word clock low on switch", 16'(word_clk), 16'h0);
    check(word == last_word, "R7 word kept on switch", word, last_word);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(word == 16'h0, "R1 reset word", word, 16'h0);
    check(word_clk == 1'b0, "R1 reset word clock", 16'(word_clk), 16'h0);
    check(word_vld == 1'b0, "R1 reset strobe", 16'(word_vld), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 walking one through every position, line source (R2)
    for (int k = 0; k < 16; k++) send_word(16'h8000 >> k, 0, "R3 walking one on line");
    send_word(16'hFFFF, 0, "R2 all ones on line");
    send_word(16'h0000, 0, "R2 all zeros on line");
    send_word(16'hA5C3, 0, "R3 mixed word on line");

    // R4 enable gaps with toggling data
    send_word(16'h3C96, 2, "R4 word with idle gaps");
    send_word(16'h8001, 1, "R4 ends with idle gaps");

    // R7 switch on a boundary, then R2 loopback
    switch_src(1'b1);
    send_word(16'h5A0F, 0, "R2 mixed word on loopback");
    for (int k = 0; k < 16; k++) send_word(~(16'h0001 << k), 0, "R3 walking zero on loopback");

    // R7 switch in the middle of a group
    for (int i = 0; i < 5; i++) accept_bit(1'b1);
    switch_src(1'b0);
    send_word(16'h0F0F, 0, "R7 word after mid-group switch");
    for (int i = 0; i < 11; i++) accept_bit(1'b0);
    switch_src(1'b1);
    switch_src(1'b0);
    send_word(16'hC35A, 1, "R7 word after back-to-back switches");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule